// File: doc/BRIEF.md
# Byte/Word Aliased Register File

This block is the general register storage of a small processor datapath. It holds eight 16-bit words. Words 0 to 3 are paired registers: each can also be reached as two separate 8-bit halves. Words 4 to 7 are pointer and index registers and can only be reached as whole words. Byte and word accesses go to the same flops, so a byte write is visible through a word read on the next cycle, and the reverse.

There are two combinational read ports and one synchronous write port. Every port carries a size bit and a 3-bit index. With the size bit set to word, the index selects one of the eight words. With the size bit set to byte, indices 0 to 3 select the low half of words 0 to 3, and indices 4 to 7 select the high half of words 0 to 3. The low byte of word 0 is the accumulator, and it is always driven on its own output.

Top module: `aliasreg_file`

## Requirements
- R1: While `rst` is high at a rising clock edge, all eight words are cleared to 0 and any write in that cycle is dropped. After that edge, every read returns 0 and `acc_lo` is 0.
- R2: A write with `wr_size`=1 (word) and `wr_en`=1 stores `wr_data` into word `wr_idx` (0..7). A word read of that index returns the new value from the next cycle onward.
- R3: A byte write (`wr_size`=0) with `wr_idx` 0..3 replaces bits [7:0] of word `wr_idx` with `wr_data[7:0]` and keeps bits [15:8] of that word.
- R4: A byte write with `wr_idx` 4..7 replaces bits [15:8] of word `wr_idx`-4 with `wr_data[7:0]`, keeps bits [7:0], and ignores `wr_data[15:8]`.
- R5: A byte read (`rX_size`=0) returns bits [7:0] of word `idx` for idx 0..3 and bits [15:8] of word `idx`-4 for idx 4..7, placed on `rX_data[7:0]`, with `rX_data[15:8]`=0.
- R6: Words 4..7 have no byte view. No byte write, at any index, changes them.
- R7: Reads are combinational. A read of a register that is written in the same cycle returns the old value. The new value appears in the following cycle.
- R8: `acc_lo` always equals bits [7:0] of word 0, which is also byte index 0.
- R9: With `wr_en`=0, no register changes, whatever the other write inputs are.
- R10: The two read ports are independent. Each one returns its own selection in the same cycle, including when both select the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable |
| wr_size | input | 1 | Write size: 1 = word, 0 = byte |
| wr_idx | input | 3 | Write register index |
| wr_data | input | 16 | Write data (byte writes use bits [7:0]) |
| ra_size | input | 1 | Port A size: 1 = word, 0 = byte |
| ra_idx | input | 3 | Port A register index |
| ra_data | output | 16 | Port A read data |
| rb_size | input | 1 | Port B size: 1 = word, 0 = byte |
| rb_idx | input | 3 | Port B register index |
| rb_data | output | 16 | Port B read data |
| acc_lo | output | 8 | Accumulator byte: low half of word 0 |

## Verification
Read data and `acc_lo` are due in the same cycle the read select is applied. A write, in either view, is due one clock edge after it is applied. The bench drives each cycle's inputs just after the falling edge. It takes the expected values from a shadow model as it stands before that cycle's write. It samples all three outputs a few nanoseconds later, before the next rising edge, and only then commits the write into the shadow. Because of that order, every same-cycle collision expects the old contents, and every later read expects the merged byte/word contents.

// File: rtl/rfa_pkg.sv
package rfa_pkg;

    localparam int WORD_W    = 16;
    localparam int BYTE_W    = 8;
    localparam int LANES     = WORD_W / BYTE_W;
    localparam int NUM_WORDS = 8;
    localparam int NUM_PAIRS = 4;
    localparam int IDX_W     = $clog2(NUM_WORDS);
    localparam int PAIR_W    = $clog2(NUM_PAIRS);

    typedef enum logic {
        ACC_BYTE = 1'b0,
        ACC_WORD = 1'b1
    } acc_size_e;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef struct packed {
        acc_size_e size;
        idx_t      idx;
    } rd_req_t;

    typedef struct packed {
        logic      en;
        acc_size_e size;
        idx_t      idx;
        word_t     data;
    } wr_req_t;

    // Decoded write: one-hot word select, per-lane enables, lane-aligned data
    typedef struct packed {
        logic [NUM_WORDS-1:0] sel;
        logic [LANES-1:0]     lane;
        word_t                data;
    } wr_cmd_t;

    // Word that holds a byte index
    function automatic idx_t byte_home(input idx_t idx);
        return idx_t'(idx[PAIR_W-1:0]);
    endfunction

    // Byte index selects the upper half when its top bit is set
    function automatic logic byte_upper(input idx_t idx);
        return idx[IDX_W-1];
    endfunction

endpackage

// File: rtl/rfa_write_decode.sv
module rfa_write_decode
    import rfa_pkg::*;
(
    input  wr_req_t req,
    output wr_cmd_t cmd
);

    always_comb begin
        cmd.sel  = '0;
        cmd.lane = '0;
        cmd.data = req.data;
        if (req.en) begin
            if (req.size == ACC_WORD) begin
                cmd.sel[req.idx] = 1'b1;
                cmd.lane         = '1;
            end else begin
                cmd.sel[byte_home(req.idx)] = 1'b1;
                cmd.data = {LANES{req.data[BYTE_W-1:0]}};
                if (byte_upper(req.idx)) begin
                    cmd.lane = LANES'(2'b10);
                end else begin
                    cmd.lane = LANES'(2'b01);
                end
            end
        end
    end

endmodule

// File: rtl/rfa_storage.sv
module rfa_storage
    import rfa_pkg::*;
#(
    parameter int N_WORDS = NUM_WORDS
) (
    input  logic                            clk,
    input  logic                            rst,
    input  wr_cmd_t                         cmd,
    output logic [N_WORDS-1:0][WORD_W-1:0]  words
);

    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            always_ff @(posedge clk) begin
                if (rst) begin
                    words[w][l*BYTE_W +: BYTE_W] <= '0;
                end else if (cmd.sel[w] && cmd.lane[l]) begin
                    words[w][l*BYTE_W +: BYTE_W] <= cmd.data[l*BYTE_W +: BYTE_W];
                end
            end
        end
    end

endmodule

// File: rtl/rfa_read_port.sv
module rfa_read_port
    import rfa_pkg::*;
#(
    parameter int N_WORDS = NUM_WORDS
) (
    input  logic [N_WORDS-1:0][WORD_W-1:0] words,
    input  rd_req_t                        req,
    output word_t                          data
);

    word_t home;

    always_comb begin
        home = words[byte_home(req.idx)];
        if (req.size == ACC_WORD) begin
            data = words[req.idx];
        end else if (byte_upper(req.idx)) begin
            data = {{(WORD_W-BYTE_W){1'b0}}, home[WORD_W-1 -: BYTE_W]};
        end else begin
            data = {{(WORD_W-BYTE_W){1'b0}}, home[BYTE_W-1:0]};
        end
    end

endmodule

// File: rtl/aliasreg_file.sv
module aliasreg_file
    import rfa_pkg::*;
#(
    parameter int N_RD = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        wr_size,
    input  logic [2:0]  wr_idx,
    input  logic [15:0] wr_data,
    input  logic        ra_size,
    input  logic [2:0]  ra_idx,
    output logic [15:0] ra_data,
    input  logic        rb_size,
    input  logic [2:0]  rb_idx,
    output logic [15:0] rb_data,
    output logic [7:0]  acc_lo
);

    wr_req_t                            wreq;
    wr_cmd_t                            wcmd;
    logic [NUM_WORDS-1:0][WORD_W-1:0]   words;
    rd_req_t                            rreq [N_RD];
    word_t                              rdat [N_RD];

    assign wreq.en   = wr_en;
    assign wreq.size = acc_size_e'(wr_size);
    assign wreq.idx  = wr_idx;
    assign wreq.data = wr_data;

    rfa_write_decode u_wdec (
        .req (wreq),
        .cmd (wcmd)
    );

    rfa_storage #(.N_WORDS(NUM_WORDS)) u_store (
        .clk   (clk),
        .rst   (rst),
        .cmd   (wcmd),
        .words (words)
    );

    assign rreq[0].size = acc_size_e'(ra_size);
    assign rreq[0].idx  = ra_idx;
    assign rreq[1].size = acc_size_e'(rb_size);
    assign rreq[1].idx  = rb_idx;

    for (genvar p = 0; p < N_RD; p++) begin : g_rd
        rfa_read_port #(.N_WORDS(NUM_WORDS)) u_rp (
            .words (words),
            .req   (rreq[p]),
            .data  (rdat[p])
        );
    end

    assign ra_data = rdat[0];
    assign rb_data = rdat[1];
    assign acc_lo  = words[0][BYTE_W-1:0];

endmodule

// File: rtl/aliasreg_file_chk.sv
module aliasreg_file_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic        wr_size,
    input logic [2:0]  wr_idx,
    input logic [15:0] wr_data,
    input logic        ra_size,
    input logic [2:0]  ra_idx,
    input logic [15:0] ra_data,
    input logic        rb_size,
    input logic [2:0]  rb_idx,
    input logic [15:0] rb_data,
    input logic [7:0]  acc_lo
);

    // R1: after a reset edge, every output reads zero
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (ra_data == 16'h0 && rb_data == 16'h0 && acc_lo == 8'h0));

    // R2: a word write is seen on port A one cycle later
    a_r2_word_visible: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_size) |=>
            (!(ra_size && ra_idx == $past(wr_idx)) || ra_data == $past(wr_data)));

    // R3: a byte write to the low half of word 0 updates the accumulator byte
    a_r3_low_byte_lands: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_size && wr_idx == 3'd0) |=> acc_lo == $past(wr_data[7:0]));

    // R4: a byte write to the high half of word 0 keeps the low half
    a_r4_high_keeps_low: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_size && wr_idx == 3'd4) |=> $stable(acc_lo));

    // R5: byte reads are zero-extended on both ports
    a_r5_byte_zero_ext: assert property (@(posedge clk) disable iff (rst)
        (!ra_size |-> ra_data[15:8] == 8'h0) and (!rb_size |-> rb_data[15:8] == 8'h0));

    // R8: a word read of word 0 agrees with the accumulator output
    a_r8_acc_coherent: assert property (@(posedge clk) disable iff (rst)
        (rb_size && rb_idx == 3'd0) |-> rb_data[7:0] == acc_lo);

    // R9: with no write enabled, the accumulator byte holds
    a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(acc_lo));

endmodule

bind aliasreg_file aliasreg_file_chk u_chk (.*);

// File: tb/sim_aliasreg_file.sv
`timescale 1ns/1ps
module sim_aliasreg_file;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, wr_size = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [15:0] wr_data = '0;
    logic        ra_size = 1'b1, rb_size = 1'b1;
    logic [2:0]  ra_idx = '0, rb_idx = '0;
    logic [15:0] ra_data, rb_data;
    logic [7:0]  acc_lo;

    always #5 clk = ~clk;

    aliasreg_file u0 (.*);

    typedef struct {
        string       tag;
        logic [15:0] ea;
        logic [15:0] eb;
        logic [7:0]  ec;
    } exp_t;

    exp_t        sbq[$];
    logic [15:0] shadow [8];
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    function automatic logic [15:0] model_read(input logic sz, input logic [2:0] idx);
        if (sz) return shadow[idx];
        if (idx[2]) return {8'h00, shadow[{1'b0, idx[1:0]}][15:8]};
        return {8'h00, shadow[{1'b0, idx[1:0]}][7:0]};
    endfunction

    task automatic step(input string tag, input logic r,
                        input logic we, input logic wsz, input logic [2:0] wi,
                        input logic [15:0] wd,
                        input logic asz, input logic [2:0] ai,
                        input logic bsz, input logic [2:0] bi);
        exp_t e;
        @(negedge clk);
        rst = r; wr_en = we; wr_size = wsz; wr_idx = wi; wr_data = wd;
        ra_size = asz; ra_idx = ai; rb_size = bsz; rb_idx = bi;
        e.tag = tag;
        e.ea  = model_read(asz, ai);
        e.eb  = model_read(bsz, bi);
        e.ec  = shadow[0][7:0];
        sbq.push_back(e);
        // commit this cycle's edge into the shadow
        if (r) begin
            for (int k = 0; k < 8; k++) shadow[k] = 16'h0;
        end else if (we) begin
            if (wsz) shadow[wi] = wd;
            else if (wi[2]) shadow[{1'b0, wi[1:0]}][15:8] = wd[7:0];
            else shadow[{1'b0, wi[1:0]}][7:0] = wd[7:0];
        end
    endtask

    task automatic rd(input string tag, input logic asz, input logic [2:0] ai,
                      input logic bsz, input logic [2:0] bi);
        step(tag, 1'b0, 1'b0, 1'b1, 3'd0, 16'hDEAD, asz, ai, bsz, bi);
    endtask

    task automatic cmp(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Monitor: samples mid-cycle, after inputs settle and before the next edge
    initial begin
        forever begin
            @(negedge clk);
            #3;
            while (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                cmp(e.tag, "ra_data", ra_data, e.ea);
                cmp(e.tag, "rb_data", rb_data, e.eb);
                cmp(e.tag, "acc_lo", {8'h00, acc_lo}, {8'h00, e.ec});
            end
        end
    end

    initial begin
        for (int k = 0; k < 8; k++) shadow[k] = 16'h0;
        repeat (2) @(posedge clk);
        // R1: reset state on all words, both ports
        for (int i = 0; i < 4; i++) rd("R1", 1'b1, 3'(i), 1'b1, 3'(i + 4));
        // R2: word writes to every index, then read back
        for (int i = 0; i < 8; i++)
            step("R2", 1'b0, 1'b1, 1'b1, 3'(i), 16'h1111 * 16'(i + 1) ^ 16'h0F0F,
                 1'b1, 3'((i + 3) % 8), 1'b1, 3'((i + 5) % 8));
        for (int i = 0; i < 8; i++) rd("R2", 1'b1, 3'(i), 1'b1, 3'(7 - i));
        // R7: same-cycle collision returns the old value, new one next cycle
        step("R7", 1'b0, 1'b1, 1'b1, 3'd2, 16'hBEEF, 1'b1, 3'd2, 1'b0, 3'd2);
        rd("R7", 1'b1, 3'd2, 1'b0, 3'd6);
        // R3: low-half byte writes keep the high half
        for (int i = 0; i < 4; i++)
            step("R3", 1'b0, 1'b1, 1'b0, 3'(i), 16'hFF00 | 16'(8'hA0 + i), 1'b1, 3'd7, 1'b0, 3'(i));
        for (int i = 0; i < 4; i++) rd("R3", 1'b1, 3'(i), 1'b0, 3'(i + 4));
        // R4: high-half byte writes keep the low half and drop wr_data[15:8]
        for (int i = 0; i < 4; i++)
            step("R4", 1'b0, 1'b1, 1'b0, 3'(i + 4), 16'h7700 | 16'(8'h50 + i), 1'b1, 3'(i), 1'b1, 3'd0);
        for (int i = 0; i < 4; i++) rd("R4", 1'b1, 3'(i), 1'b0, 3'(i + 4));
        // R5: byte reads at every index, zero-extended
        for (int i = 0; i < 8; i++) rd("R5", 1'b0, 3'(i), 1'b0, 3'(7 - i));
        // R6: byte writes at every index never reach words 4..7
        for (int i = 0; i < 8; i++)
            step("R6", 1'b0, 1'b1, 1'b0, 3'(i), 16'hC3C3, 1'b1, 3'(4 + (i % 4)), 1'b1, 3'd0);
        for (int i = 4; i < 8; i++) rd("R6", 1'b1, 3'(i), 1'b1, 3'(i - 4));
        // R8: accumulator tracks word-0 low byte through word and byte writes
        step("R8", 1'b0, 1'b1, 1'b1, 3'd0, 16'h1234, 1'b0, 3'd0, 1'b0, 3'd4);
        step("R8", 1'b0, 1'b1, 1'b0, 3'd4, 16'h00EE, 1'b0, 3'd0, 1'b1, 3'd0);
        step("R8", 1'b0, 1'b1, 1'b0, 3'd0, 16'h0099, 1'b1, 3'd0, 1'b0, 3'd4);
        rd("R8", 1'b1, 3'd0, 1'b0, 3'd0);
        // R9: disabled writes change nothing
        for (int i = 0; i < 8; i++)
            step("R9", 1'b0, 1'b0, 1'(i % 2), 3'(i), 16'hFFFF, 1'b1, 3'(i), 1'b0, 3'(i));
        for (int i = 0; i < 8; i++) rd("R9", 1'b1, 3'(i), 1'b1, 3'(i));
        // R10: ports select different and identical registers in one cycle
        rd("R10", 1'b1, 3'd5, 1'b0, 3'd3);
        rd("R10", 1'b0, 3'd7, 1'b0, 3'd7);
        rd("R10", 1'b1, 3'd1, 1'b1, 3'd1);
        // R1: reset mid-run wins over a write, then everything reads zero
        step("R1", 1'b1, 1'b1, 1'b1, 3'd0, 16'h5A5A, 1'b1, 3'd0, 1'b1, 3'd5);
        for (int i = 0; i < 8; i++) rd("R1", 1'b1, 3'(i), 1'b0, 3'(i));
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule